// File: doc/BRIEF.md
# Learned Bit-Rate Divider

This block learns the serial bit rate from a sync character that the host sends first after reset. The synchronized serial line idles high. The sync character holds the line low for exactly eight bit times: a start bit followed by seven zero data bits, which is what the byte 0x80 produces. The block counts system clock cycles across that low run and divides the count by eight, rounding to nearest, to get the number of clocks per bit. If the result is in range, the block locks and keeps the divisor until the next reset.

Once locked, the block gives the serial transceiver a bit-rate tick whenever the transceiver asks for one. It also provides a half-period value, which the receiver uses to move its sampling point to the middle of a bit after it sees a start edge. Character framing and command handling belong to the transceiver and the debug controller, not to this block.

Top module: `rate_learn`

## Requirements
- R1: While reset is active and after its release, `locked` is 0 and `bit_div`, `half_div` and `bit_tick` are all 0 until a measurement is accepted.
- R2: A measurement starts only on a high-to-low transition of `line_in`. A line that is already low when reset is released is ignored until it has been seen high.
- R3: When the line returns high after a low run of L clock cycles, and the run is accepted, `locked` is 1 and `bit_div` equals (L + 4) >> 3 from the next clock edge onward.
- R4: A run whose rounded divisor is below 8 (L < 60) is rejected. The block stays unlocked and waits for the next falling edge. L = 60 is accepted with `bit_div` = 8.
- R5: A run longer than 4096 cycles is rejected at cycle 4097 and the block stays unlocked. L = 4096 is accepted with `bit_div` = 512.
- R6: After lock, `locked` and `bit_div` stay unchanged, whatever `line_in` does, until reset.
- R7: While `locked` and `tick_en` are both 1, `bit_tick` is high for one cycle every `bit_div` cycles. The first pulse comes in the `bit_div`-th cycle with `tick_en` high. `bit_tick` is 0 whenever `tick_en` is 0 or the block is unlocked.
- R8: `half_div` equals `bit_div` shifted right by one, rounding down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it clocks both the measurement and the ticks |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Serial line, already synchronized to clk, idle high |
| tick_en | input | 1 | Transceiver active; enables the tick generator |
| locked | output | 1 | A divisor has been learned and is held |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| bit_div | output | DIV_W (10) | Learned clocks per bit |
| half_div | output | DIV_W (10) | Learned clocks per half bit |

## Verification
A wrong run count or wrong rounding shows on `bit_div` on the clock edge right after the line returns high. A broken range check shows as a lock that should not happen, or a lock that is missing, at the same edge. A lost or corrupted state after lock shows as `bit_div` drifting during later line activity. A wrong tick counter shows at the first tick, `bit_div` cycles after `tick_en` rises. A counter that does not clear shows when `tick_en` is toggled.

// File: rtl/rl_pkg.sv
// Shared types for the learned bit-rate divider.
package rl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a falling edge on the line
        ST_RUN  = 2'd1,   // counting the low run of the sync character
        ST_LOCK = 2'd2    // divisor learned and held until reset
    } rl_state_e;
endpackage

// File: rtl/rl_divcalc.sv
// Divisor derivation: turns a low-run length into clocks per bit, rounded
// to nearest, and checks the result against the supported range.
// Assumes SYNC_BITS is a power of two.
module rl_divcalc #(
    parameter int SYNC_BITS = 8,
    parameter int MIN_DIV   = 8,
    parameter int MAX_DIV   = 512,
    parameter int CNT_W     = 13,
    parameter int DIV_W     = 10
) (
    input  logic [CNT_W-1:0] run_len,
    output logic [DIV_W-1:0] cand_div,
    output logic             accept
);
    localparam int SHIFT = $clog2(SYNC_BITS);
    localparam logic [CNT_W:0] ROUND = (CNT_W+1)'(SYNC_BITS / 2);
    localparam logic [CNT_W:0] LO    = (CNT_W+1)'(MIN_DIV);
    localparam logic [CNT_W:0] HI    = (CNT_W+1)'(MAX_DIV);

    logic [CNT_W:0] rounded;
    logic [CNT_W:0] quot;

    // Add half a divisor step, divide by the sync length, then range-check.
    always_comb begin
        rounded  = {1'b0, run_len} + ROUND;
        quot     = rounded >> SHIFT;
        accept   = (quot >= LO) && (quot <= HI);
        cand_div = quot[DIV_W-1:0];
    end
endmodule

// File: rtl/rl_measure.sv
// Measurement control: waits for a falling edge, counts the low cycles,
// rejects runs that are too long, and latches an accepted divisor.
// Assumes line_in is already synchronized to clk.
module rl_measure
    import rl_pkg::*;
#(
    parameter int RUN_MAX = 4096,
    parameter int CNT_W   = 13,
    parameter int DIV_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             accept,
    input  logic [DIV_W-1:0] cand_div,
    output logic [CNT_W-1:0] run_len,
    output logic             locked,
    output logic [DIV_W-1:0] bit_div
);
    localparam logic [CNT_W-1:0] RUN_LIMIT = CNT_W'(RUN_MAX);

    rl_state_e        state;
    logic             line_q;
    logic [CNT_W-1:0] cnt;

    // Remember the previous line level; reset low so a held-low line is not an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_in;
    end

    // Sequence: idle -> count the run -> lock, or go back to idle on rejection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_div <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (line_q && !line_in) begin
                        state <= ST_RUN;
                        cnt   <= CNT_W'(1);
                    end
                end
                ST_RUN: begin
                    if (line_in) begin
                        cnt <= '0;
                        if (accept) begin
                            state   <= ST_LOCK;
                            bit_div <= cand_div;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else if (cnt == RUN_LIMIT) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_LOCK: state <= ST_LOCK;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run_len = cnt;
    assign locked  = (state == ST_LOCK);
endmodule

// File: rtl/rl_tickgen.sv
// Tick generator: a modulo-bit_div counter that pulses once per bit period
// while run is high and restarts from zero whenever run drops.
// Assumes bit_div is nonzero and stable while run is high.
module rl_tickgen #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] bit_div,
    output logic             bit_tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    // Detect the last cycle of a bit period.
    assign wrap = (cnt == bit_div - DIV_W'(1));

    // Count clocks within the bit period; clear while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (wrap)      cnt <= '0;
        else                cnt <= cnt + DIV_W'(1);
    end

    assign bit_tick = run && wrap;
endmodule

// File: rtl/rate_learn.sv
// Top of the learned bit-rate divider: measures the sync low run once after
// reset, derives the per-bit and half-bit divisors, and produces bit ticks.
// Assumes a synchronized, idle-high serial input and a synchronous active-low reset.
module rate_learn #(
    parameter int SYNC_BITS = 8,
    parameter int MIN_DIV   = 8,
    parameter int MAX_DIV   = 512,
    localparam int DIV_W    = $clog2(MAX_DIV + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             tick_en,
    output logic             locked,
    output logic             bit_tick,
    output logic [DIV_W-1:0] bit_div,
    output logic [DIV_W-1:0] half_div
);
    localparam int RUN_MAX = SYNC_BITS * MAX_DIV;
    localparam int CNT_W   = $clog2(RUN_MAX + 1);

    logic [CNT_W-1:0] run_len;
    logic [DIV_W-1:0] cand_div;
    logic             accept;

    rl_measure #(.RUN_MAX(RUN_MAX), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_meas (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .accept   (accept),
        .cand_div (cand_div),
        .run_len  (run_len),
        .locked   (locked),
        .bit_div  (bit_div)
    );

    rl_divcalc #(.SYNC_BITS(SYNC_BITS), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
                 .CNT_W(CNT_W), .DIV_W(DIV_W)) u_calc (
        .run_len  (run_len),
        .cand_div (cand_div),
        .accept   (accept)
    );

    rl_tickgen #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (locked && tick_en),
        .bit_div  (bit_div),
        .bit_tick (bit_tick)
    );

    // Half-bit value for aligning the receiver's sampling point.
    assign half_div = bit_div >> 1;
endmodule

// File: rtl/rl_checker.sv
// Checker for rate_learn: protocol properties on the ports, plus a separate
// gap counter that checks the tick spacing.
module rl_checker #(
    parameter int MIN_DIV = 8,
    parameter int MAX_DIV = 512,
    parameter int DIV_W   = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_in,
    input logic             tick_en,
    input logic             locked,
    input logic             bit_tick,
    input logic [DIV_W-1:0] bit_div
);
    logic             en;
    logic [DIV_W-1:0] gap_q;

    assign en = locked && tick_en;

    // Count enabled cycles since enable or since the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) gap_q <= '0;
        else if (bit_tick) gap_q <= '0;
        else               gap_q <= gap_q + DIV_W'(1);
    end

    p_unlocked_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (bit_div == '0 && !bit_tick));

    p_lock_on_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(line_in));

    p_div_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (bit_div >= DIV_W'(MIN_DIV) && bit_div <= DIV_W'(MAX_DIV)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(bit_div)));

    p_tick_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> en);

    p_tick_due_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && gap_q == bit_div - DIV_W'(1)) |-> bit_tick);

    p_tick_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (gap_q == bit_div - DIV_W'(1)));
endmodule

bind rate_learn rl_checker #(.MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .tick_en  (tick_en),
    .locked   (locked),
    .bit_tick (bit_tick),
    .bit_div  (bit_div)
);

// File: tb/sim_rate_learn.sv
module sim_rate_learn;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b1;
    logic       tick_en = 1'b0;
    logic       locked;
    logic       bit_tick;
    logic [9:0] bit_div;
    logic [9:0] half_div;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rate_learn u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .tick_en(tick_en),
        .locked(locked), .bit_tick(bit_tick), .bit_div(bit_div), .half_div(half_div)
    );

    function automatic int exp_div(input int len);
        int d = (len + 4) / 8;
        if (len > 4096 || d < 8) return 0;
        return d;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit line_lvl);
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; line_in = line_lvl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Hold the line low for len rising edges, then release it and wait one edge.
    task automatic low_run(input int len);
        @(negedge clk);
        line_in = 1'b0;
        repeat (len) @(negedge clk);
        line_in = 1'b1;
        @(negedge clk);
        #1;
    endtask

    task automatic sync_and_check(input string req, input int len);
        int e = exp_div(len);
        low_run(len);
        check(req, int'(locked), (e != 0) ? 1 : 0);
        check(req, int'(bit_div), e);
        check("R8", int'(half_div), e / 2);
    endtask

    // Enable ticks and compare each cycle with the expected period.
    task automatic tick_run(input int div, input int cycles);
        int bad = 0;
        @(negedge clk);
        tick_en = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            #1;
            if (bit_tick != (((i + 1) % div) == 0)) bad++;
            @(negedge clk);
        end
        tick_en = 1'b0;
        check("R7 tick period mismatches", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1: reset values
        @(negedge clk); #1;
        check("R1", int'(locked), 0);
        check("R1", int'(bit_div), 0);
        check("R1", int'(half_div), 0);
        check("R1", int'(bit_tick), 0);

        // R2: line low when reset releases is ignored
        do_reset(1'b0);
        repeat (300) @(negedge clk);
        line_in = 1'b1;
        repeat (2) @(negedge clk); #1;
        check("R2", int'(locked), 0);
        check("R2", int'(bit_div), 0);
        sync_and_check("R3", 800);

        // R7: no tick when disabled while locked
        begin
            int seen = 0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk); #1;
                if (bit_tick) seen++;
            end
            check("R7 disabled ticks", seen, 0);
        end
        tick_run(100, 450);

        // R6: later line activity does not alter the lock
        low_run(200);
        check("R6", int'(locked), 1);
        check("R6", int'(bit_div), 100);
        low_run(30);
        check("R6", int'(bit_div), 100);

        // R4: lower boundary
        do_reset(1'b1);
        sync_and_check("R4", 59);
        begin
            int seen = 0;
            @(negedge clk);
            tick_en = 1'b1;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk); #1;
                if (bit_tick) seen++;
            end
            tick_en = 1'b0;
            check("R7 unlocked ticks", seen, 0);
        end
        sync_and_check("R4", 60);
        tick_run(8, 40);

        // R5: upper boundary
        do_reset(1'b1);
        sync_and_check("R5", 4097);
        sync_and_check("R5", 4096);
        tick_run(512, 1100);

        // R3: rounding both ways
        do_reset(1'b1);
        sync_and_check("R3", 83);
        do_reset(1'b1);
        sync_and_check("R3", 84);

        // R3/R7: random lengths across the range
        for (int t = 0; t < 6; t++) begin
            int len = int'($urandom_range(60, 4096));
            do_reset(1'b1);
            repeat (int'($urandom_range(1, 20))) @(negedge clk);
            sync_and_check("R3", len);
            tick_run(exp_div(len), 3 * exp_div(len) + 5);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule